// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers a set of interrupt request lines from peripherals. Each rising edge on a line is held as a pending request. The block picks the most urgent pending source and raises one interrupt line toward the processor. When the processor acknowledges, the block answers on the next cycle with an 8-bit vector that names the winning source. The vector is a programmable base joined to the source index. The acknowledge also moves the winner from the pending set into the in-service set. An end-of-interrupt pulse retires the most urgent in-service level. Because the block tracks in-service levels, a running handler can only be pre-empted by a strictly more urgent source.

Two of these blocks can be chained. A second controller drives one input of the first, which gives fifteen usable request lines. When that cascade input wins an acknowledge, this block drives no vector. Instead it pulses a slave-select strobe, and the downstream controller supplies the vector. The cascade input and its use are chosen by parameters.

Top module: `pvic_top`

## Requirements
- R1: A 0-to-1 transition seen on `irq_in[i]` at a clock edge makes source i pending from that edge on. If nothing in service outranks it, `intr` is high in the cycle after that edge.
- R2: Index 0 is the most urgent source and index NUM_SRC-1 the least. An acknowledge serves the lowest-numbered pending source.
- R3: After an acknowledge is taken at an edge, `vec_oe` is high for the following cycle and `vec_out` equals {`vec_base`, 3-bit source index}. When `vec_oe` is low, `vec_out` is zero.
- R4: A taken acknowledge clears that source's pending bit and sets its in-service bit. A line that stays high afterwards is not pending again until it falls and rises.
- R5: `intr` is high exactly when the most urgent pending source is strictly more urgent than the most urgent in-service source, or when nothing is in service and something is pending. An equal or less urgent request is held off.
- R6: An `eoi` pulse clears only the most urgent in-service bit.
- R7: An acknowledge while `intr` is low produces no vector and no strobe, and it leaves the pending and in-service state unchanged.
- R8: When the winning source is the cascade input (index 2 by default), `slave_sel` is high for the following cycle and `vec_oe` stays low.
- R9: An acknowledge and an `eoi` in the same cycle act together. The `eoi` retires the in-service level that was most urgent before that edge, and the acknowledge adds the new winner.
- R10: A new rising edge on a source in the same cycle its acknowledge is taken leaves that source pending again.
- R11: While `rst_n` is low, `intr`, `vec_oe`, `slave_sel` and `vec_out` are all zero, and no source is pending or in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Request lines from peripherals, edge-captured |
| vec_base | input | VEC_W-log2(NUM_SRC) | Upper bits of every vector |
| inta | input | 1 | Acknowledge from the processor, one cycle per acknowledge |
| eoi | input | 1 | End-of-interrupt pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec_oe | output | 1 | Vector valid on `vec_out` this cycle |
| vec_out | output | VEC_W | Vector of the acknowledged source |
| slave_sel | output | 1 | Strobe telling the downstream controller to supply the vector |

## Verification
Two operations can land on the same clock edge: an acknowledge and an end-of-interrupt. The bench provokes this while a handler for source 6 is running and source 0 wins. It then raises source 3, which is held off only if the retired level was 6 and not the fresh 0. A second collision is a new rising edge on a line in the cycle its acknowledge is taken. The bench judges it by checking that `intr` returns after the following end-of-interrupt. A behavioural model in the bench also predicts every output on every cycle.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

   typedef enum logic [1:0] {
      RSP_NONE   = 2'd0,
      RSP_VECTOR = 2'd1,
      RSP_SLAVE  = 2'd2
   } rsp_kind_e;

endpackage

// File: rtl/pvic_prio_find.sv
module pvic_prio_find #(
   parameter int W  = 8,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  bits,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (bits[i]) begin
            found = 1'b1;
            idx   = i[IW-1:0];
         end
      end
   end

endmodule

// File: rtl/pvic_req_latch.sv
module pvic_req_latch #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_in,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] pend
);

   logic [N-1:0] prev_q;

   generate
      for (genvar g = 0; g < N; g++) begin : g_line
         logic rise;
         assign rise = req_in[g] & ~prev_q[g];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q[g] <= 1'b0;
               pend[g]   <= 1'b0;
            end else begin
               prev_q[g] <= req_in[g];
               pend[g]   <= (pend[g] & ~clr_mask[g]) | rise;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pvic_isr_track.sv
module pvic_isr_track #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic          retire,
   input  logic          top_vld,
   input  logic [IW-1:0] top_idx,
   output logic [N-1:0]  insvc
);

   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   logic [N-1:0] set_mask;
   logic [N-1:0] clr_mask;

   assign set_mask = set_en ? (ONE << set_idx) : '0;
   assign clr_mask = (retire && top_vld) ? (ONE << top_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insvc <= '0;
      end else begin
         insvc <= (insvc & ~clr_mask) | set_mask;
      end
   end

endmodule

// File: rtl/pvic_vector_out.sv
module pvic_vector_out
   import pvic_pkg::*;
#(
   parameter int  VEC_W       = 8,
   parameter int  IW          = 3,
   parameter bit  CASCADE_EN  = 1'b1,
   parameter int  CASCADE_IDX = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic [IW-1:0]       win_idx,
   input  logic [VEC_W-IW-1:0] base,
   output logic                vec_oe,
   output logic [VEC_W-1:0]    vec_out,
   output logic                slave_sel
);

   logic      is_cas;
   rsp_kind_e kind_d, kind_q;
   logic [VEC_W-1:0] vec_d, vec_q;

   generate
      if (CASCADE_EN) begin : g_cascade
         assign is_cas = (win_idx == CASCADE_IDX[IW-1:0]);
      end else begin : g_flat
         assign is_cas = 1'b0;
      end
   endgenerate

   always_comb begin
      kind_d = RSP_NONE;
      vec_d  = '0;
      if (take) begin
         if (is_cas) begin
            kind_d = RSP_SLAVE;
         end else begin
            kind_d = RSP_VECTOR;
            vec_d  = {base, win_idx};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= RSP_NONE;
         vec_q  <= '0;
      end else begin
         kind_q <= kind_d;
         vec_q  <= vec_d;
      end
   end

   assign vec_oe    = (kind_q == RSP_VECTOR);
   assign slave_sel = (kind_q == RSP_SLAVE);
   assign vec_out   = vec_oe ? vec_q : '0;

endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
   parameter int NUM_SRC     = 8,
   parameter int VEC_W       = 8,
   parameter bit CASCADE_EN  = 1'b1,
   parameter int CASCADE_IDX = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_SRC-1:0]                irq_in,
   input  logic [VEC_W-$clog2(NUM_SRC)-1:0]  vec_base,
   input  logic                              inta,
   input  logic                              eoi,
   output logic                              intr,
   output logic                              vec_oe,
   output logic [VEC_W-1:0]                  vec_out,
   output logic                              slave_sel
);

   localparam int IW = $clog2(NUM_SRC);

   generate
      if (NUM_SRC < 2) begin : g_bad_src
         $error("pvic_top: NUM_SRC must be at least 2");
      end
      if (VEC_W <= IW) begin : g_bad_vec
         $error("pvic_top: VEC_W must exceed the index width");
      end
      if (CASCADE_EN && (CASCADE_IDX < 0 || CASCADE_IDX >= NUM_SRC)) begin : g_bad_cas
         $error("pvic_top: CASCADE_IDX out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] insvc;
   logic [NUM_SRC-1:0] take_mask;
   logic               pend_vld, svc_vld;
   logic [IW-1:0]      pend_idx, svc_idx;
   logic               outranks;
   logic               take;

   pvic_prio_find #(.W(NUM_SRC), .IW(IW)) u_pend_find (
      .bits  (pend),
      .found (pend_vld),
      .idx   (pend_idx)
   );

   pvic_prio_find #(.W(NUM_SRC), .IW(IW)) u_svc_find (
      .bits  (insvc),
      .found (svc_vld),
      .idx   (svc_idx)
   );

   assign outranks  = pend_vld && (!svc_vld || (pend_idx < svc_idx));
   assign intr      = outranks;
   assign take      = inta && outranks;
   assign take_mask = take ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << pend_idx) : '0;

   pvic_req_latch #(.N(NUM_SRC)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_in   (irq_in),
      .clr_mask (take_mask),
      .pend     (pend)
   );

   pvic_isr_track #(.N(NUM_SRC), .IW(IW)) u_isr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (take),
      .set_idx (pend_idx),
      .retire  (eoi),
      .top_vld (svc_vld),
      .top_idx (svc_idx),
      .insvc   (insvc)
   );

   pvic_vector_out #(
      .VEC_W       (VEC_W),
      .IW          (IW),
      .CASCADE_EN  (CASCADE_EN),
      .CASCADE_IDX (CASCADE_IDX)
   ) u_vec (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .win_idx   (pend_idx),
      .base      (vec_base),
      .vec_oe    (vec_oe),
      .vec_out   (vec_out),
      .slave_sel (slave_sel)
   );

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
   parameter int NUM_SRC = 8,
   parameter int VEC_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               inta,
   input logic               eoi,
   input logic               intr,
   input logic               vec_oe,
   input logic [VEC_W-1:0]   vec_out,
   input logic               slave_sel,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] insvc
);

   // R3: a vector only follows a taken acknowledge
   a_r3_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> ($past(inta) && $past(intr)));

   // R3: bus is quiet without a vector
   a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_oe |-> (vec_out == '0));

   // R8: the strobe and a vector never coincide
   a_r8_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(vec_oe && slave_sel));

   // R8: strobe only follows a taken acknowledge
   a_r8_sel_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      slave_sel |-> ($past(inta) && $past(intr)));

   // R5: the processor line needs a pending source
   a_r5_intr_pending: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> (pend != '0));

   // R4: a taken acknowledge adds one in-service level
   a_r4_svc_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && intr && !eoi) |=> ($countones(insvc) == $past($countones(insvc)) + 1));

   // R6: a lone end-of-interrupt retires one level
   a_r6_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !(inta && intr) && (insvc != '0)) |=>
         ($countones(insvc) + 1 == $past($countones(insvc))));

   // R7: an acknowledge with the line low yields nothing
   a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !intr && !eoi) |=> (!vec_oe && !slave_sel && $stable(insvc)));

endmodule

bind pvic_top pvic_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .inta      (inta),
   .eoi       (eoi),
   .intr      (intr),
   .vec_oe    (vec_oe),
   .vec_out   (vec_out),
   .slave_sel (slave_sel),
   .pend      (pend),
   .insvc     (insvc)
);

// File: tb/tb_pvic_top.sv
`timescale 1ns/1ps
module tb_pvic_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic [4:0] vec_base = 5'h15;
   logic       inta = 1'b0;
   logic       eoi = 1'b0;
   logic       intr, vec_oe, slave_sel;
   logic [7:0] vec_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pvic_top dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .vec_base(vec_base),
      .inta(inta), .eoi(eoi), .intr(intr), .vec_oe(vec_oe),
      .vec_out(vec_out), .slave_sel(slave_sel)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit [7:0] m_pend, m_svc, m_prev, m_vec;
   bit       m_oe, m_sel;

   function automatic int lowest(input bit [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = '0; m_svc = '0; m_prev = '0;
         m_oe = 0; m_sel = 0; m_vec = '0;
      end else begin
         int w, t;
         bit tk;
         w  = lowest(m_pend);
         t  = lowest(m_svc);
         tk = inta && (w < t);
         if (tk) m_pend[w] = 1'b0;
         m_pend = m_pend | (irq_in & ~m_prev);
         m_prev = irq_in;
         if (eoi && t < 8) m_svc[t] = 1'b0;
         if (tk) m_svc[w] = 1'b1;
         m_oe  = tk && (w != 2);
         m_sel = tk && (w == 2);
         m_vec = m_oe ? {vec_base, w[2:0]} : 8'h00;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 model intr", intr, lowest(m_pend) < lowest(m_svc));
         chk("R3 model vec_oe", vec_oe, m_oe);
         chk("R3 model vec_out", vec_out, m_vec);
         chk("R8 model slave_sel", slave_sel, m_sel);
      end
   end

   task automatic cyc(input logic [7:0] r, input logic a, input logic e);
      irq_in = r; inta = a; eoi = e;
      @(posedge clk);
      #1;
      inta = 1'b0; eoi = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R11 intr", intr, 0);
      chk("R11 vec_oe", vec_oe, 0);
      chk("R11 slave_sel", slave_sel, 0);
      chk("R11 vec_out", vec_out, 0);
      rst_n = 1'b1;

      cyc(8'h28, 0, 0); chk("R1 intr after edges", intr, 1);
      cyc(8'h28, 1, 0); chk("R2 vec_oe", vec_oe, 1); chk("R2 winner 3", vec_out, 8'hAB);
      chk("R5 lower held off", intr, 0);
      cyc(8'h28, 0, 0); chk("R3 one cycle", vec_oe, 0); chk("R4 held line", intr, 0);
      cyc(8'h28, 0, 1); chk("R6 eoi frees 5", intr, 1);
      cyc(8'h28, 1, 0); chk("R2 winner 5", vec_out, 8'hAD);
      cyc(8'h00, 0, 1); chk("R6 empty", intr, 0);

      cyc(8'h40, 0, 0); chk("R1 line 6", intr, 1);
      cyc(8'h40, 1, 0); chk("R3 vec 6", vec_out, 8'hAE);
      cyc(8'h00, 0, 0);
      cyc(8'h40, 0, 0); chk("R5 equal held off", intr, 0);
      cyc(8'h41, 0, 0); chk("R5 nest by 0", intr, 1);
      cyc(8'h41, 1, 1); chk("R9 vec 0", vec_out, 8'hA8);
      cyc(8'h49, 0, 0); chk("R9 eoi retired 6 not 0", intr, 0);
      cyc(8'h49, 1, 0); chk("R7 no vector", vec_oe, 0); chk("R7 no strobe", slave_sel, 0);
      cyc(8'h49, 0, 1); chk("R7 state kept", intr, 1);
      cyc(8'h49, 1, 0); chk("R7 pending 3 kept", vec_out, 8'hAB);
      cyc(8'h49, 0, 1); chk("R6 frees 6", intr, 1);
      cyc(8'h49, 1, 0); chk("R3 vec 6 again", vec_out, 8'hAE);
      cyc(8'h00, 0, 1); chk("R6 all retired", intr, 0);

      cyc(8'h10, 0, 0);
      cyc(8'h00, 0, 0);
      cyc(8'h10, 1, 0); chk("R10 vec 4", vec_out, 8'hAC); chk("R10 blocked by self", intr, 0);
      cyc(8'h10, 0, 1); chk("R10 re-pending", intr, 1);
      cyc(8'h00, 1, 0); chk("R10 vec 4 again", vec_out, 8'hAC);
      cyc(8'h00, 0, 1);

      cyc(8'h04, 0, 0); chk("R1 cascade line", intr, 1);
      cyc(8'h04, 1, 0); chk("R8 strobe", slave_sel, 1); chk("R8 no vector", vec_oe, 0);
      cyc(8'h04, 0, 0); chk("R8 strobe one cycle", slave_sel, 0);
      cyc(8'h00, 0, 1); chk("R6 cascade retired", intr, 0);

      vec_base = 5'h03;
      cyc(8'h80, 0, 0);
      cyc(8'h00, 1, 0); chk("R3 new base", vec_out, 8'h1F);
      cyc(8'h00, 0, 1);
      cyc(8'h00, 1, 0); chk("R7 empty ack", vec_oe, 0);
      cyc(8'h00, 0, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule